// File: doc/BRIEF.md
# Variable-Latency Ripple Adder with Long-Carry Hold

This block adds two 8-bit operands on a ripple-carry chain of full adders. Each full adder counts as one delay unit. The pipeline clock is sized for a short budget of 5 units, not for the worst-case 8-unit carry path. Long carry chains are rare, so most additions fit the short cycle.

A detector runs beside the adder and inspects the operands as they arrive. If a generated carry could travel through more propagate stages than the budget covers, the block raises a hold flag. It then spends a second cycle on the addition before it presents the result. Every other addition completes after one cycle.

The surrounding control strobes `in_valid` with the operands. It waits for the `done` pulse, then takes the registered 9-bit result. While the block is spending an extra cycle, it ignores any new strobe.

Top module: `vl_ripple_adder`

## Requirements
- R1: On a completion, `sum` equals the full 9-bit value of a + b, with the carry out in bit 8.
- R2: An accepted operation is long exactly when some bit i has a[i]&b[i]=1 and a[j]^b[j]=1 for every j from i+1 to i+5. Otherwise it is short.
- R3: A short operation, accepted at a clock edge, gives `done`=1, `hold`=0 and the new `sum` right after that edge.
- R4: A long operation gives `hold`=1 and `done`=0 after the accepting edge. After the next edge it gives `done`=1 with the new `sum`, and `hold` stays 1.
- R5: A strobe that arrives during the extra cycle of a long operation is ignored. The long operation's result is not replaced, and no extra `done` pulse appears.
- R6: `done` is a one-cycle pulse. It appears only for an accepted operation and never while the block is idle.
- R7: During reset, `sum`, `hold` and `done` are all 0.
- R8: `sum` and `hold` keep their values in every cycle where `done` is 0, except that `hold` updates when an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| sum | output | 9 | Registered result, including the carry out |
| hold | output | 1 | The last accepted operation needed two cycles |
| done | output | 1 | Result-ready pulse |

## Verification
The bench runs every one of the 65,536 operand pairs. That sweep covers each long-chain case, including:
- a generate at bit 0 with exactly five propagate bits above it;
- the same case with only four propagate bits, which must stay short;
- chains that reach the carry out.

An off-by-one in the chain window would make hold fire too early or too late. A wrong carry into the adder's top bit would corrupt sums that carry out. During every extra cycle the bench drives a conflicting strobe. A design that accepted it would overwrite the result or pulse `done` early. Idle cycles after reset confirm that `done` does not appear on its own.

// File: rtl/vl_ripple_adder.sv
module vl_ripple_adder #(
  parameter int WIDTH  = 8,
  parameter int BUDGET = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH:0]   sum,
  output logic             hold,
  output logic             done
);
  localparam int NSTART = WIDTH - BUDGET;

  logic             busy;
  logic [WIDTH-1:0] opa_q, opb_q;
  logic [WIDTH-1:0] x, y, s, p, g;
  logic [WIDTH:0]   c;
  logic [NSTART-1:0] start_hit;
  logic             take, hold_now, load;

  assign take = in_valid & ~busy;
  assign x    = busy ? opa_q : a;
  assign y    = busy ? opb_q : b;
  assign p    = a ^ b;
  assign g    = a & b;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  for (genvar i = 0; i < NSTART; i++) begin : g_chain
    assign start_hit[i] = g[i] & (&p[i+BUDGET:i+1]);
  end

  assign hold_now = |start_hit;
  assign load     = (take & ~hold_now) | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      opa_q <= '0;
      opb_q <= '0;
      sum   <= '0;
      hold  <= 1'b0;
      done  <= 1'b0;
    end else begin
      busy <= take & hold_now;
      done <= load;
      if (take) begin
        opa_q <= a;
        opb_q <= b;
        hold  <= hold_now;
      end
      if (load) sum <= {c[WIDTH], s};
    end
  end

  // R3
  a_r3_short_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take && !hold_now |=> done && !hold);
  // R4
  a_r4_long_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take && hold_now |=> hold && !done);
  // R4, R5
  a_r5_extra_cycle_ends: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && done && hold);
  // R8
  a_r8_sum_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sum));
  // R6
  a_r6_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid) || $past(busy));
endmodule

// File: tb/vl_ripple_adder_tb.sv
module vl_ripple_adder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [8:0] sum;
  logic       hold, done;
  int         checks = 0, fails = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  vl_ripple_adder dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                         .a(a), .b(b), .sum(sum), .hold(hold), .done(done));

  function automatic bit ref_long(input logic [7:0] x, input logic [7:0] y);
    bit r = 0;
    for (int i = 0; i < 8; i++) begin
      if (x[i] && y[i]) begin
        int run = 0;
        int j = i + 1;
        while (j < 8 && (x[j] != y[j])) begin
          run++;
          j++;
        end
        if (run >= 5) r = 1;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    // R7: reset state
    repeat (2) @(negedge clk);
    chk("R7 sum", sum, 0);
    chk("R7 hold", hold, 0);
    chk("R7 done", done, 0);
    rst_n = 1'b1;
    // R6: idle after reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 idle done", done, 0);
      chk("R8 idle sum", sum, 0);
    end
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        bit lng;
        int exp_sum;
        lng = ref_long(8'(ia), 8'(ib));
        exp_sum = ia + ib;
        in_valid = 1'b1;
        a = 8'(ia);
        b = 8'(ib);
        @(negedge clk);
        if (lng) begin
          chk("R2/R4 hold first cycle", hold, 1);
          chk("R4 done low first cycle", done, 0);
          // R5: conflicting strobe during the extra cycle
          a = ~8'(ia);
          b = 8'(ib) + 8'd1;
          @(negedge clk);
          chk("R4 done second cycle", done, 1);
          chk("R1/R5 sum long", sum, exp_sum);
          chk("R4 hold kept", hold, 1);
        end else begin
          chk("R2/R3 hold low", hold, 0);
          chk("R3 done", done, 1);
          chk("R1 sum short", sum, exp_sum);
        end
        if (ia == 255 && ib == 255) begin
          in_valid = 1'b0;
          @(negedge clk);
          chk("R6 done single pulse", done, 0);
          chk("R8 sum kept", sum, exp_sum);
          chk("R8 hold kept", hold, 0);
        end
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule